// File: doc/BRIEF.md
# Shifter Operand Unit with Carry-Out

This block forms the second operand of a data-processing ALU, together with the carry bit that the shift produces. The operand is the Rm register value, shifted either by a 5-bit amount held in the instruction word or by the low byte of the Rs register value. The shift kinds are logical left, logical right, arithmetic right, rotate right, and a 33-bit rotate through the incoming carry. The unit also raises an invalid flag for register-shift encodings that name the program counter.

The decoder passes in the low 20 bits of the instruction word, the values of Rm and Rs read from the register file, the address of the current instruction and the current carry flag. One clock later the unit returns the operand, its carry-out and the invalid flag. Zero immediate amounts are not plain no-ops for every kind. For LSR and ASR a zero field means a shift by the full word. For ROR a zero field selects rotate-through-carry. Every combination of kind and amount produces an exact carry-out.

Top module: `shop_unit`

## Requirements
- R1: While rst_ni is low, operand_o, carry_o and invalid_o are 0. After reset, each output shows the result for the inputs sampled at the previous rising clock edge.
- R2: Field positions in instr_i are fixed:
  - bit 4 selects shift-by-register when 1.
  - bits [6:5] give the kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR.
  - bits [11:7] hold the immediate amount.
  - bits [11:8] are the Rs index and bits [3:0] the Rm index.
  - bits [15:12] are the Rd index and bits [19:16] the Rn index.
  - In immediate form, the Rd and Rn fields do not affect the result.
- R3: Immediate LSL by 0 returns Rm with carry_o equal to carry_i. Immediate LSL by n from 1 to 31 returns Rm shifted left by n, with carry Rm[32-n].
- R4: Immediate LSR and ASR by n from 1 to 31 shift Rm right (ASR fills with the sign bit), with carry Rm[n-1]. A zero amount means a shift by 32: LSR gives 0, ASR gives 32 copies of Rm[31], and the carry is Rm[31] in both cases.
- R5: Immediate ROR by n from 1 to 31 rotates Rm right by n, with carry Rm[n-1]. Immediate ROR by 0 returns {carry_i, Rm[31:1]} with carry Rm[0].
- R6: In immediate form, an Rm index of 15 makes the shifted value pc_i + 8 instead of rm_val_i.
- R7: In register form the amount is rs_val_i[7:0]. An amount of 0 returns Rm with carry_o equal to carry_i, whatever the kind.
- R8: Register-form LSL, LSR and ASR by 1 to 31 behave like the immediate forms. LSL by 32 gives 0 with carry Rm[0]. LSR by 32 gives 0 with carry Rm[31]. LSL or LSR by more than 32 gives 0 with carry 0.
- R9: Register-form ASR by 32 or more gives 32 copies of Rm[31] with carry Rm[31].
- R10: Register-form ROR rotates by rs_val_i[4:0]. If that field is 0 while rs_val_i[7:0] is nonzero, the result is Rm with carry Rm[31].
- R11: In register form, an Rd, Rm, Rn or Rs index equal to 15 sets invalid_o to 1, operand_o to 0 and carry_o to carry_i. Immediate form never sets invalid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 20 | Low instruction bits carrying the shift fields |
| rm_val_i | input | 32 | Value of the register selected by the Rm field |
| rs_val_i | input | 32 | Value of the register selected by the Rs field |
| pc_i | input | 32 | Address of the current instruction |
| carry_i | input | 1 | Incoming carry flag |
| operand_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |
| invalid_o | output | 1 | Register-shift encoding names register 15 |

## Verification
Two functions can act in the same cycle: program-counter substitution and the zero-amount reinterpretation. The bench sets the Rm index to 15 with an immediate ROR #0 and both carry values, and checks for {carry_i, (pc_i+8)>>1} with carry bit 0 of pc_i+8. It does the same for LSR #0 and ASR #0 on the substituted value. In register form, the invalid check competes with the shift path: index 15 is placed in each field while Rs carries a zero or an oversized amount, and the bench expects a zero operand with the incoming carry rather than any shift result. Every expected value comes from a bit-serial model that shifts one position per step.

// File: rtl/shop_pkg.sv
package shop_pkg;
  localparam int IDX_W = 4;
  localparam int IMM_W = 5;
  localparam int INSTR_W = 20;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rs;
    logic [IDX_W-1:0] rm;
    logic [IMM_W-1:0] imm;
    shift_kind_e      kind;
    logic             by_reg;
  } shift_fields_t;
endpackage

// File: rtl/shop_field_dec.sv
module shop_field_dec
  import shop_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output shift_fields_t      fields_o
);
  always_comb begin
    fields_o.rn     = instr_i[19:16];
    fields_o.rd     = instr_i[15:12];
    fields_o.rs     = instr_i[11:8];
    fields_o.imm    = instr_i[11:7];
    fields_o.kind   = shift_kind_e'(instr_i[6:5]);
    fields_o.by_reg = instr_i[4];
    fields_o.rm     = instr_i[3:0];
  end
endmodule

// File: rtl/shop_src_sel.sv
module shop_src_sel
  import shop_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int AMT_W     = 8,
  parameter int PC_OFFSET = 8
) (
  input  shift_fields_t     fields_i,
  input  logic [DATA_W-1:0] rm_val_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] pc_i,
  output logic [DATA_W-1:0] src_o,
  output logic [AMT_W-1:0]  amt_o,
  output logic              rrx_o,
  output logic              invalid_o
);
  localparam logic [IDX_W-1:0]  PC_IDX   = '1;
  localparam logic [AMT_W-1:0]  FULL_AMT = AMT_W'(DATA_W);
  localparam logic [DATA_W-1:0] PC_ADJ   = DATA_W'(PC_OFFSET);

  logic imm_zero;
  logic unused_rs_hi;

  assign unused_rs_hi = ^rs_val_i[DATA_W-1:AMT_W];
  assign imm_zero     = (fields_i.imm == '0);

  assign invalid_o = fields_i.by_reg &
                     ((fields_i.rd == PC_IDX) | (fields_i.rm == PC_IDX) |
                      (fields_i.rn == PC_IDX) | (fields_i.rs == PC_IDX));

  // immediate form reads the pipeline-advanced PC
  assign src_o = (!fields_i.by_reg && fields_i.rm == PC_IDX) ? pc_i + PC_ADJ : rm_val_i;

  assign rrx_o = !fields_i.by_reg && fields_i.kind == SH_ROR && imm_zero;

  always_comb begin
    if (fields_i.by_reg)
      amt_o = rs_val_i[AMT_W-1:0];
    else if (imm_zero && (fields_i.kind == SH_LSR || fields_i.kind == SH_ASR))
      amt_o = FULL_AMT;
    else
      amt_o = AMT_W'(fields_i.imm);
  end
endmodule

// File: rtl/shop_barrel.sv
module shop_barrel
  import shop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  shift_kind_e       kind_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              rrx_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int               SH_W     = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic              over;
  logic [AMT_W-1:0]  amt_c;
  logic [DATA_W-1:0] cand_res [4];
  logic              cand_c   [4];

  assign over  = amt_i > FULL_AMT;
  assign amt_c = over ? FULL_AMT : amt_i;

  for (genvar gk = 0; gk < 4; gk++) begin : g_kind
    if (gk == 0) begin : g_lsl
      logic [DATA_W:0] w;
      assign w            = {1'b0, src_i} << amt_c;
      assign cand_res[gk] = over ? '0 : w[DATA_W-1:0];
      assign cand_c[gk]   = over ? 1'b0 : w[DATA_W];
    end else if (gk == 1) begin : g_lsr
      logic [DATA_W:0] w;
      assign w            = {src_i, 1'b0} >> amt_c;
      assign cand_res[gk] = over ? '0 : w[DATA_W:1];
      assign cand_c[gk]   = over ? 1'b0 : w[0];
    end else if (gk == 2) begin : g_asr
      logic signed [DATA_W:0] w;
      // clamped amount saturates to a full sign fill
      assign w            = $signed({src_i, 1'b0}) >>> amt_c;
      assign cand_res[gk] = w[DATA_W:1];
      assign cand_c[gk]   = w[0];
    end else begin : g_ror
      logic [2*DATA_W-1:0] w;
      assign w            = {src_i, src_i} >> amt_i[SH_W-1:0];
      assign cand_res[gk] = w[DATA_W-1:0];
      assign cand_c[gk]   = w[DATA_W-1];
    end
  end

  always_comb begin
    if (rrx_i) begin
      res_o   = {carry_i, src_i[DATA_W-1:1]};
      carry_o = src_i[0];
    end else if (amt_i == '0) begin
      res_o   = src_i;
      carry_o = carry_i;
    end else begin
      res_o   = cand_res[kind_i];
      carry_o = cand_c[kind_i];
    end
  end
endmodule

// File: rtl/shop_unit.sv
module shop_unit
  import shop_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int AMT_W     = 8,
  parameter int PC_OFFSET = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  rm_val_i,
  input  logic [DATA_W-1:0]  rs_val_i,
  input  logic [DATA_W-1:0]  pc_i,
  input  logic               carry_i,
  output logic [DATA_W-1:0]  operand_o,
  output logic               carry_o,
  output logic               invalid_o
);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  shift_fields_t     fields;
  logic [DATA_W-1:0] src;
  logic [AMT_W-1:0]  amt;
  logic              rrx;
  logic              inv;
  logic [DATA_W-1:0] res;
  logic              res_c;
  logic              seen_q;

  shop_field_dec u_dec (
    .instr_i  (instr_i),
    .fields_o (fields)
  );

  shop_src_sel #(
    .DATA_W    (DATA_W),
    .AMT_W     (AMT_W),
    .PC_OFFSET (PC_OFFSET)
  ) u_src (
    .fields_i  (fields),
    .rm_val_i  (rm_val_i),
    .rs_val_i  (rs_val_i),
    .pc_i      (pc_i),
    .src_o     (src),
    .amt_o     (amt),
    .rrx_o     (rrx),
    .invalid_o (inv)
  );

  shop_barrel #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W)
  ) u_bar (
    .kind_i  (fields.kind),
    .amt_i   (amt),
    .rrx_i   (rrx),
    .src_i   (src),
    .carry_i (carry_i),
    .res_o   (res),
    .carry_o (res_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      operand_o <= '0;
      carry_o   <= 1'b0;
      invalid_o <= 1'b0;
      seen_q    <= 1'b0;
    end else begin
      operand_o <= inv ? '0 : res;
      carry_o   <= inv ? carry_i : res_c;
      invalid_o <= inv;
      seen_q    <= 1'b1;
    end
  end

  p_invalid_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && invalid_o) |-> (operand_o == '0 && carry_o == $past(carry_i)));

  p_imm_never_invalid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(instr_i[4])) |-> !invalid_o);

  p_reg_zero_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(instr_i[4]) && $past(rs_val_i[AMT_W-1:0]) == '0 && !invalid_o)
    |-> (operand_o == $past(rm_val_i) && carry_o == $past(carry_i)));

  p_rrx_form_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(instr_i[11:4]) == 8'b0000_0110 && $past(instr_i[3:0]) != 4'hF)
    |-> (operand_o == {$past(carry_i), $past(rm_val_i[DATA_W-1:1])} &&
         carry_o == $past(rm_val_i[0])));

  p_lsr_beyond_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(instr_i[6:4]) == 3'b011 &&
     $past(rs_val_i[AMT_W-1:0]) > FULL_AMT && !invalid_o)
    |-> (operand_o == '0 && !carry_o));
endmodule

// File: tb/shop_unit_tb_top.sv
module shop_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] instr = '0;
  logic [31:0] rm_val = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] pc = '0;
  logic        cin = 1'b0;
  logic [31:0] operand;
  logic        cout;
  logic        invalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shop_unit dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .instr_i   (instr),
    .rm_val_i  (rm_val),
    .rs_val_i  (rs_val),
    .pc_i      (pc),
    .carry_i   (cin),
    .operand_o (operand),
    .carry_o   (cout),
    .invalid_o (invalid)
  );

  function automatic logic [19:0] mk(input logic [3:0] rn, input logic [3:0] rd,
                                     input logic [4:0] mid, input logic [1:0] kind,
                                     input logic by_reg, input logic [3:0] rm);
    return {rn, rd, mid, kind, by_reg, rm};
  endfunction

  // bit-serial reference, one position per step
  task automatic model(input logic [19:0] ins, input logic [31:0] rmv, input logic [31:0] rsv,
                       input logic [31:0] pcv, input logic c_in,
                       output logic [31:0] r, output logic c, output logic inv);
    logic [1:0] kind = ins[6:5];
    int n;
    logic [31:0] v;
    inv = 1'b0;
    c = c_in;
    if (ins[4]) begin
      if (ins[19:16] == 4'hF || ins[15:12] == 4'hF || ins[11:8] == 4'hF || ins[3:0] == 4'hF) begin
        inv = 1'b1; r = '0; return;
      end
      v = rmv;
      n = int'(rsv[7:0]);
    end else begin
      v = (ins[3:0] == 4'hF) ? pcv + 32'd8 : rmv;
      n = int'(ins[11:7]);
      if (n == 0 && kind == 2'd3) begin
        r = {c_in, v[31:1]}; c = v[0]; return;
      end
      if (n == 0 && (kind == 2'd1 || kind == 2'd2)) n = 32;
    end
    for (int i = 0; i < n; i++) begin
      case (kind)
        2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    r = v;
  endtask

  task automatic run(input logic [19:0] ins, input logic [31:0] rmv, input logic [31:0] rsv,
                     input logic [31:0] pcv, input logic c_in, input string tag);
    logic [31:0] er;
    logic ec, ei;
    model(ins, rmv, rsv, pcv, c_in, er, ec, ei);
    @(negedge clk);
    instr = ins; rm_val = rmv; rs_val = rsv; pc = pcv; cin = c_in;
    @(posedge clk);
    #1;
    checks++;
    if (operand !== er || cout !== ec || invalid !== ei) begin
      errors++;
      $display("FAIL %s instr=%h rm=%h rs=%h: actual op=%h c=%b inv=%b expected op=%h c=%b inv=%b",
               tag, ins, rmv, rsv, operand, cout, invalid, er, ec, ei);
    end
  endtask

  logic [31:0] pats [4];

  initial begin
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hA5C3_3C5A;
    pats[3] = 32'h1234_8765;

    // R1: reset state with busy inputs
    instr = mk(4'h1, 4'h2, 5'd3, 2'd1, 1'b0, 4'h4);
    rm_val = 32'hFFFF_FFFF; cin = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (operand !== '0 || cout !== 1'b0 || invalid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual op=%h c=%b inv=%b expected 0 0 0", operand, cout, invalid);
    end
    @(negedge clk);
    rst_ni = 1'b1;

    // R3 R4 R5: immediate amounts, every value
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 32; n++)
        for (int p = 0; p < 4; p++)
          for (int c = 0; c < 2; c++)
            run(mk(4'h1, 4'h2, 5'(n), 2'(k), 1'b0, 4'h4), pats[p], 32'h0, 32'h0, 1'(c),
                k == 0 ? "R3" : (k == 3 ? "R5" : "R4"));

    // R2: Rd/Rn fields ignored in immediate form
    for (int f = 0; f < 15; f++)
      run(mk(4'(f), 4'(14 - f), 5'd7, 2'd2, 1'b0, 4'h9), 32'hC001_0F0F, 32'h0, 32'h0, 1'b1, "R2");

    // R7 R8 R9 R10: register amounts, upper Rs bits set
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 48; a++)
        for (int p = 0; p < 4; p++)
          for (int c = 0; c < 2; c++) begin
            int amt = (a < 41) ? a : (a == 41 ? 63 : (a == 42 ? 64 : (a == 43 ? 65 :
                      (a == 44 ? 96 : (a == 45 ? 128 : (a == 46 ? 200 : 255))))));
            string tag;
            if (amt == 0) tag = "R7";
            else if (k == 3) tag = "R10";
            else if (k == 2 && amt >= 32) tag = "R9";
            else tag = "R8";
            run(mk(4'h1, 4'h2, {4'h3, 1'b0}, 2'(k), 1'b1, 4'h4), pats[p],
                {24'hDEAD5A, 8'(amt)}, 32'h0, 1'(c), tag);
          end

    // R6: PC substitution, combined with the zero-amount forms
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 3; n++)
        for (int c = 0; c < 2; c++)
          run(mk(4'h1, 4'h2, 5'(n * 9), 2'(k), 1'b0, 4'hF), 32'h5555_5555, 32'h0,
              32'h8000_0FF9 + 32'(k), 1'(c), "R6");

    // R11: register 15 in each register-form field
    for (int pos = 0; pos < 4; pos++)
      for (int amt = 0; amt < 3; amt++)
        for (int c = 0; c < 2; c++)
          run(mk(pos == 0 ? 4'hF : 4'h1, pos == 1 ? 4'hF : 4'h2,
                 {(pos == 2 ? 4'hF : 4'h3), 1'b0}, 2'(amt), 1'b1, pos == 3 ? 4'hF : 4'h4),
              32'hF0F0_1234, 32'(amt * 40), 32'h100, 1'(c), "R11");
    // R11: index 15 in Rs/Rd bits of immediate form is not invalid
    run(mk(4'hF, 4'hF, 5'h1E, 2'd0, 1'b0, 4'h4), 32'h0000_0003, 32'h0, 32'h0, 1'b0, "R11");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule